// File: doc/BRIEF.md
# Gated-Lane SIMD Comparator

This unit compares two 64-bit unsigned operands that are cut at run time into partitions built from 8-bit lanes. A 7-bit gate vector marks the cuts: each set gate bit starts a fresh partition at the lane boundary it guards. Partitions therefore range from a single lane (8 bits) to the whole word (64 bits). Each partition produces one result bit over its full width. That bit is copied onto every output bit of the lanes the partition covers.

Besides the six two-operand relations, the unit offers three single-operand reductions over the first operand. These are all-bits-set, any-bit-set and xor parity. They are reported in the same per-lane form. The unit is purely combinational. A decode stage turns the operation code into a few strobes. A lane datapath builds the per-partition values, and a spreader copies each value across its partition.

Top module: `psc_simd_cmp`

## Requirements
- R1: Gate bit i (0..6) set to 1 places a partition boundary between lane i and lane i+1, which is bit position (i+1)*8. Lane k occupies operand bits [8k+7:8k]. Lanes not separated by a set gate bit belong to the same partition.
- R2: opSel 0 (equal) yields 1 when the two operands are identical over the whole partition. opSel 1 (not equal) yields the inverse.
- R3: opSel 2 (greater) and opSel 3 (greater or equal) compare the partition's bits of opA and opB as unsigned numbers, with the highest lane most significant.
- R4: opSel 4 (less) and opSel 5 (less or equal) compare the same way, in the opposite direction.
- R5: opSel 6 yields 1 when every bit of opA in the partition is 1.
- R6: opSel 7 yields 1 when at least one bit of opA in the partition is 1.
- R7: opSel 8 yields the xor of all bits of opA in the partition.
- R8: Every result bit of lanes in one partition carries the same value.
- R9: With all gate bits 0, the unit acts as one 64-bit operation and all eight result bits are equal.
- R10: With all gate bits 1, each lane is compared or reduced on its own.
- R11: opSel values 9 to 15 drive the result to all zeros.
- R12: For opSel 6, 7 and 8, opB has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand; the only operand used by reductions |
| opB | input | 64 | Second operand for the relations |
| gates | input | 7 | Partition cut markers, one per inner lane boundary |
| opSel | input | 4 | Operation code (0..8 valid) |
| result | output | 8 | One bit per lane, uniform within a partition |

## Verification
Two things meet in the same evaluation: the magnitude decision of a partition and the cut placed by a gate bit. A partition boundary must stop a difference in a higher lane from deciding the comparison of a lower partition. Random stimulus provokes this by using operands that differ in only a few lanes, mixed with fully random ones, under random gate patterns. Each partition is then judged against a bench model that extracts the partition as an integer. Reductions are also checked with opB re-randomised, so that any leak of the second operand shows up.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 8;
  localparam int DATA_W = LANE_W * LANES;
  localparam int OPS_W  = 4;

  typedef enum logic [OPS_W-1:0] {
    OP_EQ  = 4'd0,
    OP_NE  = 4'd1,
    OP_GT  = 4'd2,
    OP_GE  = 4'd3,
    OP_LT  = 4'd4,
    OP_LE  = 4'd5,
    OP_ALL = 4'd6,
    OP_ANY = 4'd7,
    OP_XOR = 4'd8
  } opCode_e;

  typedef struct packed {
    logic isCmp;
    logic isRed;
    logic wantEq;
    logic wantGt;
    logic wantLt;
    logic redAll;
    logic redAny;
    logic redXor;
  } strobes_t;
endpackage

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic [OPS_W-1:0]  opSel,
  input  logic [NLANES-2:0] gates,
  output strobes_t          strb,
  output logic [NLANES-1:0] startAt,
  output logic [NLANES-1:0] endAt
);
  always_comb begin
    strb = '0;
    case (opSel)
      OP_EQ:  begin strb.isCmp = 1'b1; strb.wantEq = 1'b1; end
      OP_NE:  begin strb.isCmp = 1'b1; strb.wantGt = 1'b1; strb.wantLt = 1'b1; end
      OP_GT:  begin strb.isCmp = 1'b1; strb.wantGt = 1'b1; end
      OP_GE:  begin strb.isCmp = 1'b1; strb.wantGt = 1'b1; strb.wantEq = 1'b1; end
      OP_LT:  begin strb.isCmp = 1'b1; strb.wantLt = 1'b1; end
      OP_LE:  begin strb.isCmp = 1'b1; strb.wantLt = 1'b1; strb.wantEq = 1'b1; end
      OP_ALL: begin strb.isRed = 1'b1; strb.redAll = 1'b1; end
      OP_ANY: begin strb.isRed = 1'b1; strb.redAny = 1'b1; end
      OP_XOR: begin strb.isRed = 1'b1; strb.redXor = 1'b1; end
      default: strb = '0;
    endcase
  end

  // boundary vectors: a lane starts a partition after a set gate, ends before one
  assign startAt = {gates, 1'b1};
  assign endAt   = {1'b1, gates};

  always_comb begin
    // R11
    mode_excl_chk: assert (!(strb.isCmp && strb.isRed))
      else $error("compare and reduce strobes both set");
    // R11
    bad_op_idle_chk: assert (opSel <= OP_XOR || strb == '0)
      else $error("undefined op code produced strobes");
  end
endmodule

// File: rtl/psc_lanes.sv
module psc_lanes
  import psc_pkg::*;
#(
  parameter int NLANES = LANES,
  parameter int LW     = LANE_W,
  localparam int DW    = NLANES * LW
) (
  input  logic [DW-1:0]     opA,
  input  logic [DW-1:0]     opB,
  input  strobes_t          strb,
  input  logic [NLANES-1:0] endAt,
  output logic [NLANES-1:0] partVal
);
  logic [NLANES-1:0] lnEq, lnGt, lnLt, lnAll, lnAny, lnXor;
  logic [NLANES-1:0] accEq, accGt, accLt, accAll, accAny, accXor;

  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    logic [LW-1:0] la, lb;
    assign la = opA[j*LW +: LW];
    assign lb = opB[j*LW +: LW];
    assign lnEq[j]  = (la == lb);
    assign lnGt[j]  = (la > lb);
    assign lnLt[j]  = (la < lb);
    assign lnAll[j] = &la;
    assign lnAny[j] = |la;
    assign lnXor[j] = ^la;

    // accumulate from the partition's top lane down to lane j
    if (j == NLANES - 1) begin : g_top
      assign accEq[j]  = lnEq[j];
      assign accGt[j]  = lnGt[j];
      assign accLt[j]  = lnLt[j];
      assign accAll[j] = lnAll[j];
      assign accAny[j] = lnAny[j];
      assign accXor[j] = lnXor[j];
    end else begin : g_chain
      logic brk;
      assign brk = endAt[j];
      assign accEq[j]  = brk ? lnEq[j]  : (accEq[j+1] & lnEq[j]);
      assign accGt[j]  = brk ? lnGt[j]  : (accGt[j+1] | (accEq[j+1] & lnGt[j]));
      assign accLt[j]  = brk ? lnLt[j]  : (accLt[j+1] | (accEq[j+1] & lnLt[j]));
      assign accAll[j] = brk ? lnAll[j] : (accAll[j+1] & lnAll[j]);
      assign accAny[j] = brk ? lnAny[j] : (accAny[j+1] | lnAny[j]);
      assign accXor[j] = brk ? lnXor[j] : (accXor[j+1] ^ lnXor[j]);
    end

    logic cmpBit, redBit;
    assign cmpBit = (strb.wantEq & accEq[j]) | (strb.wantGt & accGt[j]) |
                    (strb.wantLt & accLt[j]);
    assign redBit = (strb.redAll & accAll[j]) | (strb.redAny & accAny[j]) |
                    (strb.redXor & accXor[j]);
    assign partVal[j] = (strb.isCmp & cmpBit) | (strb.isRed & redBit);

    always_comb begin
      // R3
      gt_lt_excl_chk: assert (!(accGt[j] && accLt[j]))
        else $error("lane %0d greater and less at once", j);
      // R2
      eq_order_excl_chk: assert (!(accEq[j] && (accGt[j] || accLt[j])))
        else $error("lane %0d equal and ordered at once", j);
      // R5
      all_implies_any_chk: assert (!accAll[j] || accAny[j])
        else $error("lane %0d all-set without any-set", j);
    end
  end
endmodule

// File: rtl/psc_spread.sv
module psc_spread
  import psc_pkg::*;
#(
  parameter int NLANES = LANES
) (
  input  logic [NLANES-1:0] partVal,
  input  logic [NLANES-1:0] startAt,
  output logic [NLANES-1:0] laneOut
);
  // the lowest lane of a partition holds its value; copy upward
  for (genvar j = 0; j < NLANES; j++) begin : g_sp
    if (j == 0) begin : g_base
      assign laneOut[j] = partVal[j];
    end else begin : g_up
      assign laneOut[j] = startAt[j] ? partVal[j] : laneOut[j-1];
      always_comb begin
        // R8
        uniform_part_chk: assert (startAt[j] || laneOut[j] == laneOut[j-1])
          else $error("lane %0d differs from lane below inside partition", j);
      end
    end
  end

  always_comb begin
    // R9
    whole_word_chk: assert (startAt != {{(NLANES-1){1'b0}}, 1'b1} ||
                            laneOut == '0 || laneOut == '1)
      else $error("ungated word gives mixed result");
  end
endmodule

// File: rtl/psc_simd_cmp.sv
module psc_simd_cmp
  import psc_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [LANES-2:0]  gates,
  input  logic [OPS_W-1:0]  opSel,
  output logic [LANES-1:0]  result
);
  strobes_t         strb;
  logic [LANES-1:0] startAt, endAt, partVal;

  psc_ctrl #(.NLANES(LANES)) u_ctrl (
    .opSel(opSel), .gates(gates), .strb(strb),
    .startAt(startAt), .endAt(endAt)
  );

  psc_lanes #(.NLANES(LANES), .LW(LANE_W)) u_lanes (
    .opA(opA), .opB(opB), .strb(strb), .endAt(endAt), .partVal(partVal)
  );

  psc_spread #(.NLANES(LANES)) u_spread (
    .partVal(partVal), .startAt(startAt), .laneOut(result)
  );
endmodule

// File: tb/sim_psc_simd_cmp.sv
module sim_psc_simd_cmp;
  logic        clk = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [6:0]  gates = '0;
  logic [3:0]  opSel = '0;
  logic [7:0]  result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psc_simd_cmp u0 (.opA(opA), .opB(opB), .gates(gates), .opSel(opSel), .result(result));

  function automatic logic [7:0] refModel(input logic [63:0] a, input logic [63:0] b,
                                          input logic [6:0] g, input logic [3:0] op);
    logic [7:0] o = '0;
    int lo = 0;
    for (int j = 0; j < 8; j++) begin
      if (j == 7 || g[j]) begin
        int nb = (j - lo + 1) * 8;
        logic [63:0] m = (nb == 64) ? '1 : ((64'd1 << nb) - 64'd1);
        logic [63:0] va = (a >> (lo * 8)) & m;
        logic [63:0] vb = (b >> (lo * 8)) & m;
        logic r;
        case (op)
          4'd0: r = (va == vb);
          4'd1: r = (va != vb);
          4'd2: r = (va > vb);
          4'd3: r = (va >= vb);
          4'd4: r = (va < vb);
          4'd5: r = (va <= vb);
          4'd6: r = (va == m);
          4'd7: r = (va != 0);
          4'd8: r = ^va;
          default: r = 1'b0;
        endcase
        for (int k = lo; k <= j; k++) o[k] = r;
        lo = j + 1;
      end
    end
    return o;
  endfunction

  function automatic string tagFor(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [6:0] g, input logic [3:0] op, input string tag);
    logic [7:0] exp;
    @(posedge clk); #1;
    opA = a; opB = b; gates = g; opSel = op;
    @(negedge clk);
    exp = refModel(a, b, g, op);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d gates=%b got %b expected %b", tag, op, g, result, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // reset-like state: all inputs zero, op equal on zero words
    apply('0, '0, '0, 4'd0, "R9 reset");
    // R9: ungated word, difference only in lowest lane decides magnitude
    apply(64'h0000_0000_0000_0005, 64'h0000_0000_0000_0004, 7'h00, 4'd2, "R9");
    apply(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 7'h00, 4'd4, "R9");
    // R10: every lane independent
    apply(64'h0102_0304_0506_0708, 64'h0803_0304_0106_0908, 7'h7F, 4'd2, "R10");
    apply(64'hFF00_FF00_FF00_FF00, 64'h0, 7'h7F, 4'd6, "R10 R5");
    // R1: higher-lane difference must not leak across a cut
    apply(64'hFF00_0000_0000_0001, 64'h0000_0000_0000_0002, 7'h01, 4'd2, "R1");
    apply(64'h0000_0000_0100_0000, 64'h0000_0000_0000_0000, 7'h08, 4'd0, "R1");
    // R5/R6/R7 edge values
    apply('1, '0, 7'h00, 4'd6, "R5");
    apply('0, '1, 7'h00, 4'd7, "R6");
    apply(64'h0000_0001_0000_0001, '0, 7'h00, 4'd8, "R7");
    // R11: undefined codes
    for (int op = 9; op < 16; op++) apply(rnd64(), rnd64(), 7'($urandom), 4'(op), "R11");
    // R12: opB swap on reductions
    for (int i = 0; i < 60; i++) begin
      logic [63:0] a = rnd64();
      logic [6:0]  g = 7'($urandom);
      logic [3:0]  op = 4'(6 + ($urandom % 3));
      apply(a, '0, g, op, "R12");
      apply(a, rnd64(), g, op, "R12");
    end
    // random sweep: R1 R8 with each op
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a = rnd64();
      logic [63:0] b = a;
      logic [3:0]  op = 4'($urandom % 9);
      logic [6:0]  g = 7'($urandom);
      if ($urandom % 2) b = rnd64();
      else for (int k = 0; k < 8; k++)
        if ($urandom % 4 == 0) b[k*8 +: 8] = 8'($urandom);
      if ($urandom % 8 == 0) g = '0;
      apply(a, b, g, op, {tagFor(op), " R1 R8"});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule